// File: doc/BRIEF.md
# Preset-Frequency Sine and PWM Sample Generator

This block feeds an external 8-bit parallel DAC with a continuous stream of samples. A mode input chooses between a sine wave and a pulse-width-modulated square wave. A 4-bit frequency select picks one of sixteen fixed output frequencies. A 3-bit duty select sets the PWM high time in eighths of a period. There is no write strobe: the sample register drives the DAC pins all the time, and the converter follows it.

Each output period is exactly 64 sample steps long. A sample tick advances a shared 6-bit phase counter. The tick comes from a clock divider whose ratio is fixed per preset when the design is elaborated, as round(CLK_HZ / (64 × f)). The sine comes from a folded quarter-wave table in offset binary. The PWM level is high while the phase is below duty × 8. A 2:1 mux chooses one of the two, and the sample register latches it on the next clock.

The block also reports the selected frequency in hertz, so that a display can show it.

Top module: `wavegen_top`

## Requirements
- R1: `freq_hz_o` shows the preset for `freq_sel_i` combinationally. Select values 0 to 15 give 10, 20, 50, 100, 200, 500, 700, 1000, 2000, 3000, 4000, 5000, 7000, 8000, 9000 and 10000 Hz, in that order.
- R2: With the select held steady, the sample steps once every D clocks, where D = round(CLK_HZ / (64 × f)) with halves rounded up. With the default 50 MHz clock this gives D = 78 at 10 kHz and D = 15625 at 50 Hz.
- R3: For every preset, the output frequency CLK_HZ / (64 × D) lies within 1 % of the preset value.
- R4: A change of `freq_sel_i` restarts the divider on the first rising edge that samples the new value. The first sample change after the select change then appears on the (D+1)-th rising edge after that edge, where D is the new ratio.
- R5: `rst_n` is an active-low reset sampled on the rising clock edge. It clears the phase counter and the divider, and holds `sample_o` at the mid-scale value 128. In sine mode the sample is still 128 on the first clock after reset ends.
- R6: In sine mode (`mode_i` = 0) one period is exactly 64 steps long. Step 0 is 128, step 16 is 255 and step 48 is 0.
- R7: The sine samples obey three rules. For each step k, sample k plus sample k+32 equals 255. Sample 16−k equals sample 16+k for k = 1 to 15. The samples rise strictly from step 0 to step 16.
- R8: In PWM mode (`mode_i` = 1) the sample is always 0 or 255. Per 64-step period it is 255 for exactly 8 × `duty_sel_i` steps, so a duty select of 0 gives a constant 0.
- R9: The PWM high interval starts at phase step 0, which is the phase reached right after reset.
- R10: `mode_i` = 0 selects the sine and `mode_i` = 1 selects the PWM. A change of mode, or of duty, shows on `sample_o` one clock later through the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_sel_i | input | 4 | Frequency preset select |
| duty_sel_i | input | 3 | PWM duty in eighths of a period |
| mode_i | input | 1 | 0 = sine, 1 = PWM |
| sample_o | output | 8 | Offset-binary sample for the DAC |
| freq_hz_o | output | 14 | Selected preset frequency in hertz |

## Verification
The bench measures the interval between sample steps for fourteen presets, in two cases: the first step after a select change, and a steady step after that. A divider that kept counting through a change would make the first interval too short or too long. A ratio that was truncated or rounded the wrong way would be off by one clock in the steady interval. One sine period is captured from reset and checked at its anchor points and for its half-wave and quarter-wave symmetry. A table that was off by one step, or not mirrored, breaks these relations. PWM high time is integrated over whole periods for all eight duty values, and the mode mux is checked while the phase is known to be zero. An inverted threshold comparison or a reversed mux shows up as the wrong high count or the wrong level.

// File: rtl/wavegen_pkg.sv
// Package: wavegen_pkg
// Shared constants and constant functions for the sample generator.
// Assumes 64 steps per period and 8-bit offset-binary samples; the sine
// amplitude table below is sized for exactly those two values.
package wavegen_pkg;

    localparam int PHASE_W     = 6;
    localparam int SAMPLES     = 1 << PHASE_W;
    localparam int QSTEPS      = SAMPLES / 4;
    localparam int SAMPLE_W    = 8;
    localparam int SEL_W       = 4;
    localparam int NUM_PRESETS = 1 << SEL_W;
    localparam int DUTY_W      = 3;
    localparam int MID_SCALE   = 1 << (SAMPLE_W - 1);

    // Preset frequency in hertz for a select index
    function automatic int preset_hz(input int idx);
        int hz;
        case (idx)
            0:       hz = 10;
            1:       hz = 20;
            2:       hz = 50;
            3:       hz = 100;
            4:       hz = 200;
            5:       hz = 500;
            6:       hz = 700;
            7:       hz = 1000;
            8:       hz = 2000;
            9:       hz = 3000;
            10:      hz = 4000;
            11:      hz = 5000;
            12:      hz = 7000;
            13:      hz = 8000;
            14:      hz = 9000;
            15:      hz = 10000;
            default: hz = 0;
        endcase
        return hz;
    endfunction

    // Clocks per sample tick, rounded to nearest (halves up)
    function automatic int tick_ratio(input int clk_hz, input int hz);
        longint num;
        longint den;
        den = longint'(SAMPLES) * longint'(hz);
        num = longint'(clk_hz) + den / 2;
        return int'(num / den);
    endfunction

    // round(127 * sin(k * 90deg / 16)) for k = 0..16
    function automatic int quarter_amp(input int k);
        int a;
        case (k)
            0:       a = 0;
            1:       a = 12;
            2:       a = 25;
            3:       a = 37;
            4:       a = 49;
            5:       a = 60;
            6:       a = 71;
            7:       a = 81;
            8:       a = 90;
            9:       a = 98;
            10:      a = 106;
            11:      a = 112;
            12:      a = 117;
            13:      a = 122;
            14:      a = 125;
            15:      a = 126;
            default: a = 127;
        endcase
        return a;
    endfunction

    // Offset-binary sine sample for one phase step, folded from the quarter
    function automatic int sine_at(input int p);
        int quad;
        int j;
        int v;
        quad = p / QSTEPS;
        j    = p % QSTEPS;
        case (quad)
            0:       v = MID_SCALE + quarter_amp(j);
            1:       v = MID_SCALE + quarter_amp(QSTEPS - j);
            2:       v = MID_SCALE - 1 - quarter_amp(j);
            default: v = MID_SCALE - 1 - quarter_amp(QSTEPS - j);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/wavegen_freq_map.sv
// Module: wavegen_freq_map
// Turns the frequency select into a tick divide ratio and a display value.
// Both tables are built at elaboration from the preset list, so the
// hardware is two constant lookups with no runtime division.
// Assumes CLK_HZ is large enough that every ratio is at least 1.
module wavegen_freq_map
    import wavegen_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int DIV_W  = 24,
    parameter int HZ_W   = 14
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [DIV_W-1:0] div_o,
    output logic [HZ_W-1:0]  hz_o
);

    logic [DIV_W-1:0] div_tab [NUM_PRESETS];
    logic [HZ_W-1:0]  hz_tab  [NUM_PRESETS];

    // One constant entry per preset
    for (genvar gi = 0; gi < NUM_PRESETS; gi++) begin : g_preset
        localparam int ENTRY_HZ  = preset_hz(gi);
        localparam int ENTRY_DIV = tick_ratio(CLK_HZ, ENTRY_HZ);
        assign div_tab[gi] = DIV_W'(ENTRY_DIV);
        assign hz_tab[gi]  = HZ_W'(ENTRY_HZ);
    end

    // Select the active preset
    always_comb begin
        div_o = div_tab[sel_i];
        hz_o  = hz_tab[sel_i];
    end

endmodule

// File: rtl/wavegen_sample_clock.sv
// Module: wavegen_sample_clock
// Divides the system clock down to the sample tick and advances the shared
// phase counter once per tick. A change of the frequency select restarts
// the divider so that the new ratio counts from zero.
// Assumes div_i >= 1 and that div_i follows sel_i combinationally.
module wavegen_sample_clock
    import wavegen_pkg::*;
#(
    parameter int DIV_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DIV_W-1:0]   div_i,
    output logic [PHASE_W-1:0] phase_o
);

    logic [SEL_W-1:0]   sel_q;
    logic [DIV_W-1:0]   cnt;
    logic [PHASE_W-1:0] phase;
    logic               restart;
    logic               tick;

    // Detect a select change and the last clock of a tick interval
    always_comb begin
        restart = (sel_i != sel_q);
        tick    = !restart && (cnt == div_i - 1'b1);
    end

    // Remember the select seen on the previous edge
    always_ff @(posedge clk) begin
        sel_q <= sel_i;
    end

    // Divider counter: clears on reset, on a select change and at the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Phase counter: one step per tick, wraps after a full period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            phase <= phase + 1'b1;
        end
    end

    assign phase_o = phase;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (phase == '0) && (cnt == '0)); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt < div_i)); // R2

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick) |-> $stable(phase)); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick) |-> (phase == PHASE_W'($past(phase) + 1'b1))); // R6

endmodule

// File: rtl/wavegen_shaper.sv
// Module: wavegen_shaper
// Makes both waveforms from the phase and returns the one chosen by the
// mode. The sine comes from a table of one value per step, built at
// elaboration by folding a quarter wave. The PWM is high while the phase
// is below duty times one eighth of the period.
// Purely combinational; the caller registers the result.
module wavegen_shaper
    import wavegen_pkg::*;
(
    input  logic [PHASE_W-1:0]  phase_i,
    input  logic [DUTY_W-1:0]   duty_i,
    input  logic                mode_i,
    output logic [SAMPLE_W-1:0] shaped_o
);

    localparam logic [SAMPLE_W-1:0] LEVEL_HI = '1;
    localparam logic [SAMPLE_W-1:0] LEVEL_LO = '0;

    logic [SAMPLE_W-1:0] sine_rom [SAMPLES];
    logic [SAMPLE_W-1:0] sine_val;
    logic [SAMPLE_W-1:0] pwm_val;
    logic [PHASE_W-1:0]  threshold;

    // One constant sine sample per phase step
    for (genvar gp = 0; gp < SAMPLES; gp++) begin : g_sine
        localparam int STEP_VAL = sine_at(gp);
        assign sine_rom[gp] = SAMPLE_W'(STEP_VAL);
    end

    // Duty threshold in phase steps, then compare against the phase
    always_comb begin
        threshold = {duty_i, {(PHASE_W - DUTY_W){1'b0}}};
        pwm_val   = (phase_i < threshold) ? LEVEL_HI : LEVEL_LO;
        sine_val  = sine_rom[phase_i];
    end

    // 2:1 mux between the two waveforms
    always_comb begin
        shaped_o = mode_i ? pwm_val : sine_val;
    end

endmodule

// File: rtl/wavegen_top.sv
// Module: wavegen_top
// Preset-frequency sine/PWM sample generator for a parallel DAC.
// The select sets a tick divider, the tick steps a 64-entry phase, and the
// phase is shaped into a sine or PWM sample, which is registered and
// driven out continuously. Assumes all inputs are synchronous to clk.
module wavegen_top
    import wavegen_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int DIV_W  = 24,
    parameter int HZ_W   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    freq_sel_i,
    input  logic [DUTY_W-1:0]   duty_sel_i,
    input  logic                mode_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic [HZ_W-1:0]     freq_hz_o
);

    localparam logic [SAMPLE_W-1:0] RESET_LEVEL = SAMPLE_W'(MID_SCALE);

    logic [DIV_W-1:0]    div;
    logic [PHASE_W-1:0]  phase;
    logic [SAMPLE_W-1:0] shaped;
    logic [SAMPLE_W-1:0] sample_q;

    wavegen_freq_map #(
        .CLK_HZ (CLK_HZ),
        .DIV_W  (DIV_W),
        .HZ_W   (HZ_W)
    ) u_map (
        .sel_i  (freq_sel_i),
        .div_o  (div),
        .hz_o   (freq_hz_o)
    );

    wavegen_sample_clock #(
        .DIV_W   (DIV_W)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (freq_sel_i),
        .div_i   (div),
        .phase_o (phase)
    );

    wavegen_shaper u_shape (
        .phase_i  (phase),
        .duty_i   (duty_sel_i),
        .mode_i   (mode_i),
        .shaped_o (shaped)
    );

    // Output register: holds mid-scale in reset, otherwise the shaped sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= RESET_LEVEL;
        end else begin
            sample_q <= shaped;
        end
    end

    assign sample_o = sample_q;

    AST_PWM_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mode_i) |-> (sample_o == '0) || (sample_o == '1)); // R8

    AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mode_i) && ($past(duty_sel_i) == '0) |-> (sample_o == '0)); // R8

    AST_SINE_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(mode_i) && ($past(phase) == PHASE_W'(QSTEPS)) |-> (sample_o == '1)); // R6

    AST_PWM_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mode_i) && ($past(phase) == '0) && ($past(duty_sel_i) != '0)
        |-> (sample_o == '1)); // R9

endmodule

// File: tb/wavegen_top_test.sv
// Bench for wavegen_top: scoreboard of expected step intervals plus
// direct checks of reset, mux, sine shape and PWM high time.
module wavegen_top_test;

    localparam int CLK_HZ  = 50_000_000;
    localparam int WD_LIMIT = 195_000;

    typedef struct {
        int clocks;
        int hz;
        bit steady;
        int sel;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] freq_sel = 4'd15;
    logic [2:0] duty_sel = 3'd7;
    logic       mode = 1'b0;
    logic [7:0] sample;
    logic [13:0] freq_hz;

    int checks = 0;
    int failures = 0;
    exp_t exp_q[$];
    int presets[16] = '{10, 20, 50, 100, 200, 500, 700, 1000,
                        2000, 3000, 4000, 5000, 7000, 8000, 9000, 10000};

    wavegen_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_sel_i (freq_sel),
        .duty_sel_i (duty_sel),
        .mode_i     (mode),
        .sample_o   (sample),
        .freq_hz_o  (freq_hz)
    );

    always #4 clk = ~clk;

    function automatic int exp_div(input int f);
        return (CLK_HZ + 32 * f) / (64 * f);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive_tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_change();
        logic [7:0] prev;
        prev = sample;
        @(negedge clk);
        while (sample == prev) @(negedge clk);
    endtask

    task automatic do_reset();
        drive_tick();
        rst_n = 1'b0;
        repeat (4) drive_tick();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: counts clocks between sample steps and scores them
    int mcnt = 0;
    logic [7:0] last_sample = 8'd0;
    logic [3:0] last_sel = 4'd0;
    always @(negedge clk) begin
        if (freq_sel != last_sel) mcnt = 0;
        else mcnt++;
        last_sel = freq_sel;
        if (sample != last_sample) begin
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.steady) begin
                    longint err;
                    check(mcnt == e.clocks, "R2 steady step interval", mcnt, e.clocks);
                    err = longint'(CLK_HZ) - 64 * longint'(mcnt) * longint'(e.hz);
                    if (err < 0) err = -err;
                    check(err * 100 <= longint'(CLK_HZ), "R3 frequency within 1%",
                          CLK_HZ / (64 * mcnt), e.hz);
                end else begin
                    check(mcnt == e.clocks, "R4 first step after select change", mcnt, e.clocks);
                end
            end
            mcnt = 0;
        end
        last_sample = sample;
    end

    // Driver: change select just after a step and queue the expectations
    task automatic measure(input int s);
        exp_t e;
        wait_change();
        drive_tick();
        freq_sel = 4'(s);
        e.hz = presets[s];
        e.sel = s;
        e.clocks = exp_div(presets[s]) + 2;
        e.steady = 1'b0;
        exp_q.push_back(e);
        e.clocks = exp_div(presets[s]);
        e.steady = 1'b1;
        exp_q.push_back(e);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seq[65];
        int hi;
        bit levels_ok;

        // R5: reset state and first clock after reset
        do_reset();
        check(sample == 8'd128, "R5 sample at reset release", sample, 128);
        drive_tick();
        @(negedge clk);
        check(sample == 8'd128, "R5 sine sample after reset", sample, 128);

        // R1: preset frequency values
        for (int s = 0; s < 16; s++) begin
            freq_sel = 4'(s);
            #1;
            check(freq_hz == 14'(presets[s]), "R1 preset hz", freq_hz, presets[s]);
        end
        freq_sel = 4'd15;

        // R10 and R9: mux and latency while the phase is known to be 0
        do_reset();
        drive_tick();
        mode = 1'b1;
        @(negedge clk);
        check(sample == 8'd128, "R10 one-clock latency on mode change", sample, 128);
        @(negedge clk);
        check(sample == 8'd255, "R9 PWM high at phase 0", sample, 255);
        drive_tick();
        mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sample == 8'd128, "R10 sine selected by mode 0", sample, 128);
        drive_tick();
        mode = 1'b1;
        duty_sel = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check(sample == 8'd0, "R8 duty 0 gives low", sample, 0);
        drive_tick();
        mode = 1'b0;

        // R6 and R7: capture one sine period from reset
        do_reset();
        seq[0] = sample;
        for (int k = 1; k <= 64; k++) begin
            wait_change();
            seq[k] = sample;
        end
        check(seq[0] == 128, "R6 step 0", seq[0], 128);
        check(seq[16] == 255, "R6 step 16 peak", seq[16], 255);
        check(seq[48] == 0, "R6 step 48 trough", seq[48], 0);
        check(seq[64] == 128, "R6 period of 64 steps", seq[64], 128);
        for (int k = 0; k < 32; k++)
            check(seq[k] + seq[k + 32] == 255, "R7 half-wave sum", seq[k] + seq[k + 32], 255);
        for (int k = 1; k < 16; k++)
            check(seq[16 - k] == seq[16 + k], "R7 quarter mirror", seq[16 + k], seq[16 - k]);
        for (int k = 0; k < 16; k++)
            check(seq[k + 1] > seq[k], "R7 rising first quarter", seq[k + 1], seq[k] + 1);

        // R8: PWM high time over one whole period for each duty
        mode = 1'b1;
        for (int d = 0; d < 8; d++) begin
            drive_tick();
            duty_sel = 3'(d);
            repeat (100) @(negedge clk);
            hi = 0;
            levels_ok = 1'b1;
            for (int c = 0; c < 64 * exp_div(10000); c++) begin
                @(negedge clk);
                if (sample == 8'd255) hi++;
                else if (sample != 8'd0) levels_ok = 1'b0;
            end
            check(hi == 8 * d * exp_div(10000), "R8 PWM high clocks per period",
                  hi, 8 * d * exp_div(10000));
            check(levels_ok, "R8 PWM levels only 0 or 255", levels_ok, 1);
        end

        // R2, R3, R4: step intervals for presets 2..15
        drive_tick();
        mode = 1'b0;
        repeat (4) @(negedge clk);
        for (int s = 2; s < 16; s++) measure(s);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule